// File: doc/BRIEF.md
# Data Cache Way Tag Checker

This block inspects the tags of one data-cache set, one way at a time. A single start pulse latches a 13-bit cache index and launches a walk over the four ways. For each way the block requests a tag. That tag arrives as a 32-bit upper word and a 64-bit lower word. The block then decodes the 5-bit coherence state held in the upper word and, for a legal state, checks two parity bits that protect the physical tag in the lower word.

The block reports one result per way. Each result carries a state-error flag, an address-error flag, a compact state code, the physical address rebuilt from the tag and the index, and the bank and set numbers taken from the index. The replacement ordering from way 0 is captured once per walk. The error flags of all four ways are ORed into two walk-level flags that are presented with a done pulse.

The sequencer has four states:
- IDLE waits for start.
- FETCH raises the tag request and waits for the tag to arrive.
- REPORT presents the result for one way for one cycle, then either moves on to the next way in FETCH or, after way 3, proceeds to DONE.
- DONE pulses done and returns to IDLE.

Top module: `dtag_walk_check`

## Requirements
- R1: The coherence state is tag_hi[29:25]. Its code on res_code is: 0x0F gives 1 (shared), 0x13 gives 2 (noncoherent clean), 0x19 gives 3 (noncoherent dirty), 0x16 gives 4 (coherent clean), 0x1C gives 5 (coherent dirty), 0x00 gives 0 (invalid), and any other value gives 7 (unknown).
- R2: res_state_err is 1 exactly when the state is not one of the five legal encodings; the value 0x00 counts as not legal.
- R3: For a legal state, res_addr_err is set when tag_lo[11] differs from the XOR of tag_lo[39:26].
- R4: For a legal state, res_addr_err is set when tag_lo[10] differs from the XOR of tag_lo[25:13].
- R5: res_addr_err is 0 whenever the state is not legal, whatever the parity bits hold.
- R6: res_pa is {tag_lo[39:13], idx[12:0]}, where idx is the value sampled when the start is accepted.
- R7: res_bank is {idx[12], idx[5]} and res_set is idx[11:6].
- R8: lru_order holds tag_hi[21:14] of way 0 from that way's report until the next accepted start.
- R9: After reset all outputs are 0. A start in IDLE requests ways 0, 1, 2 and 3 in order, with rd_req held until rd_valid. res_valid is high for one cycle in the cycle after each rd_valid, with res_way naming the way. done pulses for one cycle after the fourth result.
- R10: acc_state_err and acc_addr_err are the OR of the respective per-way flags over the walk. They are cleared by an accepted start and held until the next one.
- R11: A start asserted while a walk is in progress is ignored; the walk, its index and its accumulated flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a four-way walk (accepted in IDLE only) |
| idx | input | 13 | Cache index, sampled at accepted start |
| rd_req | output | 1 | Tag request for way rd_way |
| rd_way | output | 2 | Way being requested |
| rd_valid | input | 1 | Tag words are valid this cycle |
| tag_hi | input | 32 | Upper tag word (state, replacement order) |
| tag_lo | input | 64 | Lower tag word (physical tag, parity) |
| res_valid | output | 1 | Per-way result valid |
| res_way | output | 2 | Way of the result |
| res_state_err | output | 1 | Illegal coherence state |
| res_addr_err | output | 1 | Physical-tag parity fault |
| res_code | output | 3 | Decoded state code |
| res_pa | output | 40 | Rebuilt physical address |
| res_bank | output | 2 | Bank number |
| res_set | output | 6 | Set number |
| lru_order | output | 8 | Replacement order from way 0 |
| done | output | 1 | Walk complete |
| acc_state_err | output | 1 | OR of state errors in the walk |
| acc_addr_err | output | 1 | OR of parity faults in the walk |

## Verification
Two functions can meet in one result cycle: the state check and the parity check. The bench provokes this by sending tags whose state is illegal (zero or an unknown code) together with one or both parity bits flipped. Such a result is judged correct only if it shows the state error, the unknown or invalid code and no address error. The per-way report and the walk accumulation also meet when a fault sits on way 3. The bench places faults there and checks that the done cycle already carries the flag from that last way.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
    localparam int TAG_HI_W  = 32;
    localparam int TAG_LO_W  = 64;
    localparam int IDX_W     = 13;
    localparam int PA_W      = 40;
    localparam int ST_W      = 5;
    localparam int ST_LSB    = 25;
    localparam int LRU_LSB   = 14;
    localparam int LRU_W     = 8;
    localparam int PTAG_LSB  = 13;
    localparam int BANK_W    = 2;
    localparam int SET_W     = 6;
    localparam int SET_LSB   = 6;
    localparam int BANK_HI_B = 12;
    localparam int BANK_LO_B = 5;
    localparam int NGRP      = 2;

    localparam logic [ST_W-1:0] ENC_SHD = 5'h0F;
    localparam logic [ST_W-1:0] ENC_NCC = 5'h13;
    localparam logic [ST_W-1:0] ENC_NCD = 5'h19;
    localparam logic [ST_W-1:0] ENC_CCL = 5'h16;
    localparam logic [ST_W-1:0] ENC_CDR = 5'h1C;
    localparam logic [ST_W-1:0] ENC_INV = 5'h00;

    typedef enum logic [2:0] {
        CODE_INV = 3'd0,
        CODE_SHD = 3'd1,
        CODE_NCC = 3'd2,
        CODE_NCD = 3'd3,
        CODE_CCL = 3'd4,
        CODE_CDR = 3'd5,
        CODE_BAD = 3'd7
    } st_code_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_REPORT = 2'd2,
        S_DONE   = 2'd3
    } walk_st_e;
endpackage

// File: rtl/dtag_state_decode.sv
module dtag_state_decode
    import dtag_pkg::*;
(
    input  logic [ST_W-1:0] raw,
    output st_code_e        code,
    output logic            legal
);
    always_comb begin
        legal = 1'b1;
        unique case (raw)
            ENC_SHD: code = CODE_SHD;
            ENC_NCC: code = CODE_NCC;
            ENC_NCD: code = CODE_NCD;
            ENC_CCL: code = CODE_CCL;
            ENC_CDR: code = CODE_CDR;
            ENC_INV: begin
                code  = CODE_INV;
                legal = 1'b0;
            end
            default: begin
                code  = CODE_BAD;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dtag_parity_check.sv
module dtag_parity_check
    import dtag_pkg::*;
(
    input  logic [TAG_LO_W-1:0] tag_lo,
    input  logic                enable,
    output logic                fault
);
    localparam int GRP_HI [NGRP] = '{39, 25};
    localparam int GRP_LO [NGRP] = '{26, 13};
    localparam int GRP_CK [NGRP] = '{11, 10};

    logic [NGRP-1:0] mism;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign mism[g] = tag_lo[GRP_CK[g]] ^ (^tag_lo[GRP_HI[g]:GRP_LO[g]]);
        end
    endgenerate

    assign fault = enable & (|mism);
endmodule

// File: rtl/dtag_addr_form.sv
module dtag_addr_form
    import dtag_pkg::*;
(
    input  logic [IDX_W-1:0]    idx,
    input  logic [TAG_LO_W-1:0] tag_lo,
    output logic [PA_W-1:0]     pa,
    output logic [BANK_W-1:0]   bank,
    output logic [SET_W-1:0]    set_no
);
    assign pa     = {tag_lo[PA_W-1:PTAG_LSB], idx};
    assign bank   = {idx[BANK_HI_B], idx[BANK_LO_B]};
    assign set_no = idx[SET_LSB +: SET_W];
endmodule

// File: rtl/dtag_walk_check.sv
module dtag_walk_check
    import dtag_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IDX_W-1:0]    idx,
    output logic                rd_req,
    output logic [WAY_W-1:0]    rd_way,
    input  logic                rd_valid,
    input  logic [TAG_HI_W-1:0] tag_hi,
    input  logic [TAG_LO_W-1:0] tag_lo,
    output logic                res_valid,
    output logic [WAY_W-1:0]    res_way,
    output logic                res_state_err,
    output logic                res_addr_err,
    output logic [2:0]          res_code,
    output logic [PA_W-1:0]     res_pa,
    output logic [BANK_W-1:0]   res_bank,
    output logic [SET_W-1:0]    res_set,
    output logic [LRU_W-1:0]    lru_order,
    output logic                done,
    output logic                acc_state_err,
    output logic                acc_addr_err
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

    walk_st_e         state_q, state_d;
    logic [WAY_W-1:0] way_q, way_d;
    logic [IDX_W-1:0] idx_q;

    st_code_e          dec_code;
    logic              dec_legal;
    logic              par_fault;
    logic [PA_W-1:0]   f_pa;
    logic [BANK_W-1:0] f_bank;
    logic [SET_W-1:0]  f_set;

    logic start_ok, cap;
    assign start_ok = (state_q == S_IDLE) && start;
    assign cap      = (state_q == S_FETCH) && rd_valid;

    dtag_state_decode u_dec (
        .raw   (tag_hi[ST_LSB +: ST_W]),
        .code  (dec_code),
        .legal (dec_legal)
    );

    dtag_parity_check u_par (
        .tag_lo (tag_lo),
        .enable (dec_legal),
        .fault  (par_fault)
    );

    dtag_addr_form u_addr (
        .idx    (idx_q),
        .tag_lo (tag_lo),
        .pa     (f_pa),
        .bank   (f_bank),
        .set_no (f_set)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            way_q   <= way_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        way_d   = way_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_FETCH;
                    way_d   = '0;
                end
            end
            S_FETCH: begin
                if (rd_valid) state_d = S_REPORT;
            end
            S_REPORT: begin
                if (way_q == LAST_WAY) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_FETCH;
                    way_d   = way_q + 1'b1;
                end
            end
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        rd_req    = 1'b0;
        res_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_FETCH:  rd_req    = 1'b1;
            S_REPORT: res_valid = 1'b1;
            S_DONE:   done      = 1'b1;
        endcase
    end
    assign rd_way = way_q;

    // result capture and accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q         <= '0;
            res_way       <= '0;
            res_state_err <= 1'b0;
            res_addr_err  <= 1'b0;
            res_code      <= CODE_INV;
            res_pa        <= '0;
            res_bank      <= '0;
            res_set       <= '0;
            lru_order     <= '0;
            acc_state_err <= 1'b0;
            acc_addr_err  <= 1'b0;
        end else begin
            if (start_ok) begin
                idx_q         <= idx;
                acc_state_err <= 1'b0;
                acc_addr_err  <= 1'b0;
                lru_order     <= '0;
            end
            if (cap) begin
                res_way       <= way_q;
                res_state_err <= ~dec_legal;
                res_addr_err  <= par_fault;
                res_code      <= dec_code;
                res_pa        <= f_pa;
                res_bank      <= f_bank;
                res_set       <= f_set;
                acc_state_err <= acc_state_err | ~dec_legal;
                acc_addr_err  <= acc_addr_err | par_fault;
                if (way_q == '0) lru_order <= tag_hi[LRU_LSB +: LRU_W];
            end
        end
    end

    AST_ADDR_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_state_err) |-> !res_addr_err); // R5
    AST_CODE_FLAG_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_state_err == (res_code == CODE_INV || res_code == CODE_BAD))); // R2
    AST_DONE_AFTER_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid)); // R9
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!res_valid && !done)); // R9
    AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state_err && !start) |=> acc_state_err); // R10
    AST_ACC_COVERS_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_addr_err) |=> acc_addr_err); // R10
    AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid) == 1'b0 && res_way != '0) |-> $stable(res_bank)); // R11
endmodule

// File: tb/sim_dtag_walk_check.sv
module sim_dtag_walk_check;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] idx = '0;
    logic        rd_req;
    logic [1:0]  rd_way;
    logic        rd_valid = 1'b0;
    logic [31:0] tag_hi = '0;
    logic [63:0] tag_lo = '0;
    logic        res_valid, res_state_err, res_addr_err, done, acc_state_err, acc_addr_err;
    logic [1:0]  res_way, res_bank;
    logic [2:0]  res_code;
    logic [39:0] res_pa;
    logic [5:0]  res_set;
    logic [7:0]  lru_order;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtag_walk_check u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .idx(idx),
        .rd_req(rd_req), .rd_way(rd_way), .rd_valid(rd_valid),
        .tag_hi(tag_hi), .tag_lo(tag_lo),
        .res_valid(res_valid), .res_way(res_way), .res_state_err(res_state_err),
        .res_addr_err(res_addr_err), .res_code(res_code), .res_pa(res_pa),
        .res_bank(res_bank), .res_set(res_set), .lru_order(lru_order),
        .done(done), .acc_state_err(acc_state_err), .acc_addr_err(acc_addr_err)
    );

    typedef struct {
        logic [1:0]  way;
        logic        serr, aerr;
        logic [2:0]  code;
        logic [39:0] pa;
        logic [1:0]  bank;
        logic [5:0]  set_no;
    } exp_t;

    typedef struct {
        logic       serr, aerr;
        logic [7:0] lru;
    } acc_t;

    exp_t exp_q[$];
    acc_t acc_q[$];
    int checks = 0;
    int fails = 0;
    int results_seen = 0;

    logic [31:0] his [4];
    logic [63:0] los [4];
    int          dly [4];
    int          wcnt = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] code_of(input logic [4:0] s);
        case (s)
            5'h0F: return 3'd1;
            5'h13: return 3'd2;
            5'h19: return 3'd3;
            5'h16: return 3'd4;
            5'h1C: return 3'd5;
            5'h00: return 3'd0;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [31:0] mk_hi(input logic [4:0] s, input logic [7:0] lru);
        logic [31:0] h;
        h = 32'hA5A5_A5A5;
        h[29:25] = s;
        h[21:14] = lru;
        return h;
    endfunction

    function automatic logic [63:0] mk_lo(input logic [26:0] ptag, input logic f11, input logic f10);
        logic [63:0] l;
        l = 64'h5A5A_0000_0000_0000;
        l[39:13] = ptag;
        l[11] = (^l[39:26]) ^ f11;
        l[10] = (^l[25:13]) ^ f10;
        return l;
    endfunction

    // responder: supplies the tag for the requested way after a per-way delay
    always @(negedge clk) begin
        if (rd_req && !rd_valid) begin
            if (wcnt >= dly[rd_way]) begin
                rd_valid <= 1'b1;
                tag_hi   <= his[rd_way];
                tag_lo   <= los[rd_way];
                wcnt     <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            results_seen++;
            if (exp_q.size() == 0) begin
                chk("R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R9 way order", res_way, e.way);
                chk("R2 state_err", res_state_err, e.serr);
                chk("R3 R4 R5 addr_err", res_addr_err, e.aerr);
                chk("R1 code", res_code, e.code);
                chk("R6 pa", res_pa, e.pa);
                chk("R7 bank", res_bank, e.bank);
                chk("R7 set", res_set, e.set_no);
            end
        end
        if (rst_n && done) begin
            if (acc_q.size() == 0) begin
                chk("R9 unexpected done", 1, 0);
            end else begin
                acc_t a;
                a = acc_q.pop_front();
                chk("R10 acc_state_err", acc_state_err, a.serr);
                chk("R10 acc_addr_err", acc_addr_err, a.aerr);
                chk("R8 lru_order", lru_order, a.lru);
            end
        end
    end

    task automatic run_walk(input logic [12:0] ix, input bit extra_start);
        acc_t a;
        a.serr = 0;
        a.aerr = 0;
        a.lru  = his[0][21:14];
        for (int w = 0; w < 4; w++) begin
            exp_t e;
            logic legal;
            logic p_bad;
            e.way  = 2'(w);
            e.code = code_of(his[w][29:25]);
            legal  = (e.code != 3'd0) && (e.code != 3'd7);
            p_bad  = (los[w][11] != ^los[w][39:26]) || (los[w][10] != ^los[w][25:13]);
            e.serr = !legal;
            e.aerr = legal && p_bad;
            e.pa   = {los[w][39:13], ix};
            e.bank = {ix[12], ix[5]};
            e.set_no = ix[11:6];
            a.serr |= e.serr;
            a.aerr |= e.aerr;
            exp_q.push_back(e);
        end
        acc_q.push_back(a);
        @(negedge clk);
        idx   = ix;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx   = ~ix;
        if (extra_start) begin
            // R11: start pulse while the walk runs
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R9 done single pulse", done, 0);
        chk("R10 acc held serr", acc_state_err, a.serr);
        chk("R10 acc held aerr", acc_addr_err, a.aerr);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) dly[i] = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset rd_req", rd_req, 0);
        chk("R9 reset res_valid", res_valid, 0);
        chk("R9 reset done", done, 0);
        chk("R9 reset acc", {acc_state_err, acc_addr_err}, 0);
        chk("R9 reset lru", lru_order, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // walk 1: legal states, clean parity
        his[0] = mk_hi(5'h0F, 8'hE4); los[0] = mk_lo(27'h1234567, 0, 0);
        his[1] = mk_hi(5'h13, 8'h1B); los[1] = mk_lo(27'h7FFFFFF, 0, 0);
        his[2] = mk_hi(5'h19, 8'h00); los[2] = mk_lo(27'h0000001, 0, 0);
        his[3] = mk_hi(5'h16, 8'hFF); los[3] = mk_lo(27'h2AAAAAA, 0, 0);
        run_walk(13'h1FE0, 0);

        // walk 2: illegal states with parity faults, faults on legal ways
        dly[0] = 2; dly[1] = 0; dly[2] = 3; dly[3] = 1;
        his[0] = mk_hi(5'h00, 8'h93); los[0] = mk_lo(27'h0F0F0F0, 1, 1);
        his[1] = mk_hi(5'h05, 8'h00); los[1] = mk_lo(27'h5555555, 1, 0);
        his[2] = mk_hi(5'h1C, 8'h00); los[2] = mk_lo(27'h3333333, 1, 0);
        his[3] = mk_hi(5'h16, 8'h00); los[3] = mk_lo(27'h4444444, 0, 1);
        run_walk(13'h1020, 0);

        // walk 3: all clean except way 3 (last way fault reaches acc)
        dly[0] = 0; dly[2] = 0;
        his[0] = mk_hi(5'h1C, 8'h39); los[0] = mk_lo(27'h0000000, 0, 0);
        his[1] = mk_hi(5'h16, 8'h00); los[1] = mk_lo(27'h6DB6DB6, 0, 0);
        his[2] = mk_hi(5'h0F, 8'h00); los[2] = mk_lo(27'h1111111, 0, 0);
        his[3] = mk_hi(5'h13, 8'h00); los[3] = mk_lo(27'h7654321, 1, 1);
        run_walk(13'h0020, 0);

        // walk 4: unknown state on last way, start during walk ignored
        dly[1] = 2;
        his[0] = mk_hi(5'h19, 8'h4E); los[0] = mk_lo(27'h0ABCDEF, 0, 0);
        his[1] = mk_hi(5'h0F, 8'h00); los[1] = mk_lo(27'h0FEDCBA, 0, 0);
        his[2] = mk_hi(5'h13, 8'h00); los[2] = mk_lo(27'h0000FFF, 0, 0);
        his[3] = mk_hi(5'h1F, 8'h00); los[3] = mk_lo(27'h1FFF000, 0, 1);
        run_walk(13'h0FC0, 1);

        repeat (4) @(negedge clk);
        chk("R11 no extra walk results", results_seen, 16);
        chk("R11 queue drained", exp_q.size() + acc_q.size(), 0);
        chk("R9 idle after walks", rd_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule